// File: doc/BRIEF.md
# Seven-Slot Flat-Panel Lane Serializer

This block turns parallel pixel-lane words into serial streams for a low-voltage differential flat-panel link. Each data lane receives a 7-bit slice per pixel period and sends those seven bits one per bit clock. The bit clock is an input running at seven times the pixel rate, so one unit interval is one bit-clock period. At the fastest supported panel clock of 7.5 ns per period, one unit interval is about 1.07 ns. Up to ten data lanes share one forwarded clock lane, and that clock lane is serialized by the same slot machinery.

A free-running slot counter steps through slots 0 to 6. A new word is taken only at the word boundary, which is the edge that ends slot 6. If no word is offered there, the lanes send the previous word again. Within a period, the bits of each slice leave in the fixed order 1, 0, 6, 5, 4, 3, 2. This order is neither MSB-first nor LSB-first. It places bits 1 and 0 of a word directly after bit 2 of the word before it. Mapping colour bits onto lanes, the analog drivers and the clock multiplier all sit outside this block.

Top module: `pixlane_serializer`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is sampled low, `lane_out` and `clk_lane` are all zero, the slot counter returns to 0 and the held word is cleared.
- R2: Number the rising edges of `bit_clk` at which `rst_n` is high, starting from 1 after reset. Edge k leaves the block in slot k mod 7, so slot 6 is the cycle before every seventh edge.
- R3: `word_in` is captured only when `load` is high at an edge that ends slot 6. On the next cycle, slot 0 of that word appears on `lane_out`.
- R4: In slot s (0..6), lane L drives word bit L*7+b, where b runs 1, 0, 6, 5, 4, 3, 2 for s = 0..6. Lane L uses bits L*7 to L*7+6 of `word_in`.
- R5: `clk_lane` carries 1, 1, 0, 0, 0, 1, 1 in slots 0 to 6. The exception is the first cycle after reset is released, which still shows the reset value.
- R6: When `load` is low at the edge that ends slot 6, every lane sends the previously held word again in the next period.
- R7: `load` and `word_in` have no effect at edges that end slots 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Word offer, sampled at the edge that ends slot 6 |
| word_in | input | LANES*7 | Parallel word, 7 bits per lane, lane 0 in the low bits |
| lane_out | output | LANES | Serial data, one bit per lane per slot |
| clk_lane | output | 1 | Forwarded clock lane pattern |

## Verification
Solid all-ones and all-zeros words show that no slot is stuck. The alternating and staggered patterns tell the 1,0,6,5,4,3,2 order apart from plain MSB-first or LSB-first orders, and reveal any lane-to-lane crossing. A single set bit checks that exactly one slot of one lane is driven. Periods run without `load`, or with `load` and noise driven mid-period, to separate a correct hold from a premature capture. A reset in the middle of a period checks that slot counting restarts.

// File: rtl/pixlane_serializer.sv
module pixlane_serializer #(
  parameter int LANES = 10
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [LANES*7-1:0]   word_in,
  output logic [LANES-1:0]     lane_out,
  output logic                 clk_lane
);
  localparam int SLOTS = 7;
  localparam int WW = LANES * SLOTS;
  localparam logic [2:0] LAST = 3'(SLOTS - 1);
  localparam logic [6:0] CLK_PAT = 7'b1100011;

  logic [2:0]    phase;
  logic [WW-1:0] held;

  function automatic logic [2:0] slot_bit(input logic [2:0] s);
    logic [3:0] t;
    t = (s < 3'd2) ? (4'd1 - {1'b0, s}) : (4'd8 - {1'b0, s});
    return t[2:0];
  endfunction

  function automatic logic [LANES-1:0] pick(input logic [WW-1:0] w, input logic [2:0] s);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = w[l*SLOTS + int'(slot_bit(s))];
    return r;
  endfunction

  wire             take      = load && (phase == LAST);
  wire [2:0]       nxt_phase = (phase == LAST) ? 3'd0 : phase + 3'd1;
  wire [WW-1:0]    nxt_word  = take ? word_in : held;

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      phase    <= '0;
      held     <= '0;
      lane_out <= '0;
      clk_lane <= 1'b0;
    end else begin
      phase    <= nxt_phase;
      if (take) held <= word_in;
      lane_out <= pick(nxt_word, nxt_phase);
      clk_lane <= CLK_PAT[nxt_phase];
    end
  end

  a_r2_phase_step: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (phase != LAST) |=> (phase == $past(phase) + 3'd1));
  a_r2_phase_wrap: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == 3'd0));
  a_r3_capture: assert property (@(posedge bit_clk) disable iff (!rst_n)
    take |=> (lane_out == pick($past(word_in), 3'd0)));
  a_r6_hold: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !take |=> $stable(held));
  a_r4_slot_data: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $past(rst_n) |-> (lane_out == pick(held, phase)));
  a_r5_clk_lane: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $past(rst_n) |-> (clk_lane == CLK_PAT[phase]));
endmodule

// File: tb/pixlane_serializer_test.sv
module pixlane_serializer_test;
  localparam int LANES = 10;
  localparam int WW = LANES * 7;
  localparam int NV = 6;
  localparam int ORD [7] = '{1, 0, 6, 5, 4, 3, 2};
  localparam logic [6:0] CPAT = 7'b1100011;

  localparam logic [WW-1:0] VW [NV] = '{
    70'h3F_FFFF_FFFF_FFFF_FFFF,
    70'h15_5555_5555_5555_5555,
    70'h01_0204_0810_2040_8102,
    70'h12_3456_789A_BCDE_F012,
    70'h2C_9E37_79B9_7F4A_7C15,
    70'h00_0000_0000_0000_0002 };
  localparam bit VL [NV] = '{1, 1, 1, 0, 1, 1};
  localparam bit VN [NV] = '{0, 0, 1, 0, 1, 0};

  logic bit_clk = 0, rst_n = 0, load = 0;
  logic [WW-1:0] word_in = '0;
  logic [LANES-1:0] lane_out;
  logic clk_lane;
  logic [WW-1:0] model = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  pixlane_serializer #(.LANES(LANES)) uut (
    .bit_clk(bit_clk), .rst_n(rst_n), .load(load), .word_in(word_in),
    .lane_out(lane_out), .clk_lane(clk_lane));

  always #4 bit_clk = ~bit_clk;

  function automatic logic [LANES-1:0] expect_lanes(input logic [WW-1:0] w, input int s);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = w[l*7 + ORD[s]];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic period(input logic [WW-1:0] w, input bit ld, input bit noise);
    load = ld;
    word_in = w;
    if (ld) model = w;
    for (int s = 0; s < 7; s++) begin
      @(posedge bit_clk);
      @(negedge bit_clk);
      chk($sformatf("R4 data slot %0d", s), 16'(lane_out), 16'(expect_lanes(model, s)));
      chk($sformatf("R5 clock slot %0d", s), 16'(clk_lane), 16'(CPAT[6-s]));
      if (s < 6) begin
        load = noise;
        word_in = ~w;
      end
    end
  endtask

  task automatic prime();
    @(negedge bit_clk);
    rst_n = 1;
    @(posedge bit_clk);
    @(negedge bit_clk);
    chk("R1 first cycle data", 16'(lane_out), 16'h0);
    chk("R5 first cycle clock", 16'(clk_lane), 16'h1);
    repeat (5) @(posedge bit_clk);
    @(negedge bit_clk);
  endtask

  initial begin
    repeat (3) @(posedge bit_clk);
    @(negedge bit_clk);
    chk("R1 reset data", 16'(lane_out), 16'h0);
    chk("R1 reset clock", 16'(clk_lane), 16'h0);
    prime();
    for (int i = 0; i < NV; i++) begin
      period(VW[i], VL[i], VN[i]);
      if (!VL[i]) chk("R6 held word", 16'(lane_out), 16'(expect_lanes(VW[i-1], 6)));
    end
    period(70'h0, 1'b0, 1'b1);
    chk("R7 noise ignored", 16'(model[15:0]), 16'(VW[NV-1][15:0]));
    period(70'h0, 1'b1, 1'b0);
    period(VW[1], 1'b1, 1'b0);
    @(negedge bit_clk);
    load = 0;
    @(posedge bit_clk);
    @(negedge bit_clk);
    rst_n = 0;
    @(posedge bit_clk);
    @(negedge bit_clk);
    chk("R1 mid-period reset data", 16'(lane_out), 16'h0);
    chk("R1 mid-period reset clock", 16'(clk_lane), 16'h0);
    model = '0;
    prime();
    chk("R2 slot 6 reached", 16'(clk_lane), 16'(CPAT[0]));
    period(VW[2], 1'b1, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge bit_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule